// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a chain of 4-bit synchronous binary counter stages that acts as one wide counter. The state of every stage changes only on the rising clock edge. The one exception is the active-low clear, which is asynchronous and zeroes every stage at once, whether or not a clock edge occurs. The active-low load is synchronous: at the next edge it copies the data inputs into all stages, whatever the enables are doing.

Each stage has two count enables:
- The parallel enable goes to every stage unchanged.
- The carry-path enable of a stage comes from the stage below it. The first stage takes it from the block input.

A stage drives its carry output high while its carry-path enable is high and the stage holds 15. That carry becomes the carry-path enable of the next stage. The chain therefore counts in plain binary over the full width with no extra gating.

Each stage decodes its control inputs at every edge into one of three modes:
- **MODE_LOAD** is chosen when load is low.
- **MODE_COUNT** is chosen when load is high and both enables are high.
- **MODE_HOLD** covers every other case.

The mode decides how the stage register moves at that edge:
- **HOLD→HOLD** keeps the stored value.
- **LOAD** takes the value on the data inputs.
- **COUNT** advances the value by one, and 15 wraps to 0.

Clear overrides all three modes.

Top module: `pcc_cascade`

## Requirements
- R1: While `clr_n` is low, `q` is zero and `stage_co` is zero. This takes effect immediately, with no clock edge needed, and holds whatever `load_n`, `en_par`, `en_carry` and `din` are.
- R2: If `load_n` is low at a rising edge, `q` equals `din` after that edge, whatever the levels of `en_par` and `en_carry`.
- R3: If `load_n`, `en_par` and `en_carry` are all high at a rising edge, `q` becomes the old `q` plus one.
- R4: If `load_n` is high at a rising edge and either enable is low, `q` keeps its value.
- R5: Bit g of `stage_co` is high exactly when `en_carry` is high and every stage from 0 up to g holds 15. `en_par` has no effect on `stage_co`.
- R6: When all of `q` is ones and a count occurs, `q` wraps to zero.
- R7: Changes on `load_n`, `en_par`, `en_carry` or `din` between edges do not change `q`. Only the levels present at a rising edge matter.
- R8: The stages form one binary number: stage g occupies bits `[4g+3:4g]` of `q` and `din`. A stage above 0 advances only when every stage below it holds 15.
- R9: Clear takes priority over load. A load that arrives while `clr_n` is low leaves `q` at zero.
- R10: After a clear, a preset of stage 0 to 12 followed by counting gives 13, 14, 15, 0 and then carries into stage 1. The carry out of stage 0 is high only in the 15 state. Setting both enables low then holds the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_carry | input | 1 | Carry-path enable of stage 0 |
| din | input | STAGES*STAGE_W | Parallel load data, stage 0 in the low bits |
| q | output | STAGES*STAGE_W | Counter value, stage 0 in the low bits |
| stage_co | output | STAGES | Carry output of each stage, bit g for stage g |

## Verification
Each stage's state is its own count register, so a wrong count appears on `q` immediately after the edge that stored it. A wrong mode decode shows the same way, with a held value where a count was due or the reverse. A fault in the carry lookahead shows on `stage_co` in the same cycle as the state that should raise it. It then shows on `q` one edge later, because the next stage steps or fails to step.

The bench therefore checks `q` and `stage_co` right after every edge. It also places checks between edges to catch any path that bypasses the clock, which covers both the asynchronous clear and mid-cycle control changes.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    // Per-edge operating mode of one counter stage.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2
    } ctr_mode_e;

endpackage

// File: rtl/pcc_mode_dec.sv
module pcc_mode_dec
    import pcc_pkg::*;
(
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_carry,
    output ctr_mode_e mode
);

    logic both_en;

    assign both_en = en_par & en_carry;

    // Priority: load over count over hold (clear is handled at the register).
    always_comb begin
        unique casez ({load_n, both_en})
            2'b0?:   mode = MODE_LOAD;
            2'b11:   mode = MODE_COUNT;
            2'b10:   mode = MODE_HOLD;
            default: mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/pcc_stage.sv
module pcc_stage
    import pcc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_par,
    input  logic         en_carry,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         carry_out
);

    localparam logic [W-1:0] STEP    = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

    ctr_mode_e    mode;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    pcc_mode_dec u_dec (
        .load_n   (load_n),
        .en_par   (en_par),
        .en_carry (en_carry),
        .mode     (mode)
    );

    // Next-state selection by mode.
    always_comb begin
        unique case (mode)
            MODE_LOAD:  cnt_d = din;
            MODE_COUNT: cnt_d = cnt_q + STEP;
            MODE_HOLD:  cnt_d = cnt_q;
            default:    cnt_d = cnt_q;
        endcase
    end

    // State register: asynchronous clear wins over every mode.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Outputs: value and lookahead carry, combinational from state.
    always_comb begin
        q         = cnt_q;
        carry_out = en_carry & (cnt_q == TOP_VAL);
    end

endmodule

// File: rtl/pcc_cascade.sv
module pcc_cascade #(
    parameter int STAGES  = 3,
    parameter int STAGE_W = 4
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        en_par,
    input  logic                        en_carry,
    input  logic [STAGES*STAGE_W-1:0]   din,
    output logic [STAGES*STAGE_W-1:0]   q,
    output logic [STAGES-1:0]           stage_co
);

    localparam int TOTAL_W = STAGES * STAGE_W;

    logic [TOTAL_W-1:0] q_int;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic link_en;

        if (g == 0) begin : g_first
            assign link_en = en_carry;
        end else begin : g_next
            assign link_en = stage_co[g-1];
        end

        pcc_stage #(.W(STAGE_W)) u_stage (
            .clk       (clk),
            .clr_n     (clr_n),
            .load_n    (load_n),
            .en_par    (en_par),
            .en_carry  (link_en),
            .din       (din[g*STAGE_W +: STAGE_W]),
            .q         (q_int[g*STAGE_W +: STAGE_W]),
            .carry_out (stage_co[g])
        );
    end

    assign q = q_int;

endmodule

// File: rtl/pcc_cascade_chk.sv
module pcc_cascade_chk #(
    parameter int STAGES  = 3,
    parameter int STAGE_W = 4
) (
    input logic                      clk,
    input logic                      clr_n,
    input logic                      load_n,
    input logic                      en_par,
    input logic                      en_carry,
    input logic [STAGES*STAGE_W-1:0] din,
    input logic [STAGES*STAGE_W-1:0] q,
    input logic [STAGES-1:0]         stage_co
);

    localparam int TOTAL_W = STAGES * STAGE_W;
    localparam logic [TOTAL_W-1:0] ONE = {{(TOTAL_W-1){1'b0}}, 1'b1};

    // R1: the first edge after clear release still sees zero.
    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> (q == '0));

    // R2: load copies the data regardless of enables.
    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    // R3 and R6: a wide count step of one, wrapping modulo the full width.
    p_count_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_carry) |=> (q == $past(q) + ONE));

    // R4: hold unless both enables are high.
    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_carry)) |=> $stable(q));

    // R5 and R8: each stage carry equals the lookahead over all lower bits.
    for (genvar g = 0; g < STAGES; g++) begin : g_co
        p_carry_r5: assert property (@(posedge clk) disable iff (!clr_n)
            stage_co[g] == (en_carry && (&q[(g+1)*STAGE_W-1:0])));
    end

endmodule

bind pcc_cascade pcc_cascade_chk #(.STAGES(STAGES), .STAGE_W(STAGE_W)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .en_par   (en_par),
    .en_carry (en_carry),
    .din      (din),
    .q        (q),
    .stage_co (stage_co)
);

// File: tb/pcc_cascade_bench.sv
module pcc_cascade_bench;

    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        load_n = 1'b1;
    logic        en_par = 1'b1;
    logic        en_carry = 1'b1;
    logic [11:0] din = 12'hFFF;
    logic [11:0] q;
    logic [2:0]  stage_co;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pcc_cascade #(.STAGES(3), .STAGE_W(4)) u_pcc_cascade (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_carry(en_carry), .din(din), .q(q), .stage_co(stage_co)
    );

    // {load_n, en_par, en_carry, din[11:0], exp_q[11:0], exp_co[2:0]}
    localparam logic [29:0] VEC [0:18] = '{
        {1'b0, 1'b1, 1'b1, 12'h00C, 12'h00C, 3'b000},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'h00D, 3'b000},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'h00E, 3'b000},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'h00F, 3'b001},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'h010, 3'b000},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'h011, 3'b000},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'h012, 3'b000},
        {1'b1, 1'b0, 1'b0, 12'h000, 12'h012, 3'b000},
        {1'b1, 1'b0, 1'b1, 12'h000, 12'h012, 3'b000},
        {1'b0, 1'b0, 1'b0, 12'hEFE, 12'hEFE, 3'b000},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'hEFF, 3'b011},
        {1'b1, 1'b0, 1'b1, 12'h000, 12'hEFF, 3'b011},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'hF00, 3'b000},
        {1'b0, 1'b1, 1'b1, 12'hFFE, 12'hFFE, 3'b000},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'hFFF, 3'b111},
        {1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 3'b000},
        {1'b1, 1'b1, 1'b0, 12'h000, 12'h000, 3'b000},
        {1'b0, 1'b1, 1'b0, 12'hFFF, 12'hFFF, 3'b000},
        {1'b1, 1'b0, 1'b1, 12'h000, 12'hFFF, 3'b111}
    };

    function automatic string vec_tag(input int i);
        if (i <= 7) return "R10 preset-count-hold sequence";
        case (i)
            8:       return "R4 hold with only carry enable";
            9:       return "R2 load with enables low";
            10:      return "R8 carry into middle stage";
            11:      return "R5 parallel enable ignored by carry";
            12:      return "R8 ripple into upper stage";
            13:      return "R2 load while enabled";
            14:      return "R5 all carries high";
            15:      return "R6 wrap to zero";
            16:      return "R4 hold when carry enable low";
            17:      return "R5 carry gated by carry enable";
            default: return "R5 carry without counting";
        endcase
    endfunction

    task automatic check(input string tag, input logic [11:0] eq, input logic [2:0] eco);
        n_checks++;
        if (q !== eq || stage_co !== eco) begin
            n_err++;
            $display("FAIL %s: q=%h co=%b expected q=%h co=%b", tag, q, stage_co, eq, eco);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired (all R): q=%h expected end of test", q);
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] exp_q;
        logic [2:0]  exp_co;

        // R1 and R9: reset state with load and enables active.
        repeat (2) @(posedge clk);
        #1 check("R1 reset state", 12'h000, 3'b000);
        @(negedge clk) load_n = 1'b0; din = 12'hABC;
        @(posedge clk);
        #1 check("R9 clear over load", 12'h000, 3'b000);
        @(negedge clk) clr_n = 1'b1; load_n = 1'b1;

        // Table walk.
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            {load_n, en_par, en_carry, din, exp_q, exp_co} = VEC[i];
            @(posedge clk);
            #1 check(vec_tag(i), exp_q, exp_co);
        end

        // R7: glitches between edges; edge sees hold with both enables low.
        #1 load_n = 1'b0; din = 12'h123;
        #1 load_n = 1'b1; en_par = 1'b1;
        @(negedge clk) en_par = 1'b0; en_carry = 1'b0;
        #1 check("R7 mid-cycle controls before edge", 12'hFFF, 3'b000);
        @(posedge clk);
        #1 check("R7 edge levels only", 12'hFFF, 3'b000);

        // R1: clear in the middle of a cycle, held across one edge.
        @(negedge clk) load_n = 1'b0; din = 12'h5A5; en_par = 1'b1; en_carry = 1'b1;
        @(posedge clk);
        #1 check("R2 load before clear", 12'h5A5, 3'b000);
        load_n = 1'b1;
        #2 clr_n = 1'b0;
        #1 check("R1 mid-cycle clear", 12'h000, 3'b000);
        @(posedge clk);
        #1 check("R1 clear holds across edge", 12'h000, 3'b000);
        @(negedge clk) clr_n = 1'b1;
        @(posedge clk);
        #1 check("R3 count after clear release", 12'h001, 3'b000);

        // R8 and R6: long cascaded run against a bench model.
        @(negedge clk) load_n = 1'b0; din = 12'hFF0;
        @(posedge clk);
        #1 check("R2 load for cascade run", 12'hFF0, 3'b000);
        exp_q = 12'hFF0;
        @(negedge clk) load_n = 1'b1;
        for (int k = 0; k < 40; k++) begin
            en_par = (k % 3 != 2);
            @(posedge clk);
            if (en_par) exp_q = exp_q + 12'h001;
            exp_co = {&exp_q[11:0], &exp_q[7:0], &exp_q[3:0]};
            #1 check("R8 cascaded count", exp_q, exp_co);
            @(negedge clk);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule